// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the bus pins of a flash-style memory. It watches bus write cycles and recognises multi-cycle unlock sequences. When a program sequence completes, it sends a single-clock program request with the target address and data to the array back end. It also selects whether read data comes from the array or from a small identification register.

Normal programming takes four writes. After a bypass-entry sequence, each program takes only two writes until an exit sequence is given. An accelerate input forces bypass mode while it is held, with no command needed. An autoselect sequence makes reads return identification codes until a reset command is written. Bus inputs are sampled on the block clock. A write is taken once per low phase of the combined write condition.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write is taken only when ce_n=0, we_n=0 and oe_n=1 on a clock edge where that condition did not hold at the edge before. A cycle with oe_n=0 or ce_n=1 has no effect on the sequence.
- R2: Four writes program one word: 0xAA to address 0x555, 0x55 to 0x2AA, 0xA0 to 0x555, then data D to address A. The commands sit on din[7:0] and the unlock addresses on addr[10:0]. prog_req goes high in the cycle after the fourth write, with prog_addr=A and prog_data=D.
- R3: A write that fails to match its step in any of the first three positions (wrong data or wrong address) returns the decoder to read-array state. No request follows from the rest of that sequence.
- R4: The two unlock writes followed by 0x20 at 0x555 enter bypass mode. In bypass mode, 0xA0 then data D at address A issues one request, and this can be repeated.
- R5: In bypass mode, 0x90 followed by 0x00 returns to normal mode. If the write after 0x90 is any other value, the decoder stays in bypass mode.
- R6: The two unlock writes followed by 0x90 at 0x555 enter autoselect. While read_sel_id=1, dout gives a manufacturer code when addr[1:0]=0, a device code when addr[1:0]=1, and zero otherwise. The upper eight bits of dout are zero. Outside autoselect, dout equals array_rdata.
- R7: Writing 0xF0 in autoselect returns to read-array state.
- R8: One clock after accel rises, the decoder is in bypass mode with no command written. When accel falls, the decoder returns to normal mode.
- R9: When busy is high at the final write of a sequence, no request is issued. The sequence still ends.
- R10: prog_req lasts exactly one clock.
- R11: After reset, the decoder is in read-array state with prog_req=0 and read_sel_id=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Bus address |
| din | input | DATA_W | Bus write data |
| accel | input | 1 | Forces bypass mode while high |
| busy | input | 1 | Back end cannot accept a request |
| array_rdata | input | DATA_W | Read data from the array |
| prog_req | output | 1 | One-clock program request |
| prog_addr | output | ADDR_W | Program address |
| prog_data | output | DATA_W | Program data |
| read_sel_id | output | 1 | Reads come from the identification register |
| dout | output | DATA_W | Read data to the bus |

## Verification
A write applied before a clock edge is taken at that edge. Any request it causes appears on prog_req right after the same edge. The bench therefore drives each write at a falling edge and samples prog_req, prog_addr and prog_data at the next falling edge. It also checks that the earlier writes of each sequence raised no request. dout and read_sel_id respond to state within the same cycle and to addr with no register delay, so the bench reads them a short delay after driving a read address. A change on accel takes effect one clock later, so the bench waits two clocks after toggling it before writing.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    ST_READ, ST_UL1, ST_UL2, ST_PROG, ST_AUTO, ST_BYP, ST_BYP_PROG, ST_BYP_EXIT
  } seq_state_t;

  localparam logic [7:0] CMD_UL1    = 8'hAA;
  localparam logic [7:0] CMD_UL2    = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_AUTO   = 8'h90;
  localparam logic [7:0] CMD_BYPASS = 8'h20;
  localparam logic [7:0] CMD_RESET  = 8'hF0;
  localparam logic [7:0] CMD_EXIT2  = 8'h00;
  localparam logic [10:0] UL_ADDR1  = 11'h555;
  localparam logic [10:0] UL_ADDR2  = 11'h2AA;

  function automatic logic in_bypass(input seq_state_t s);
    return (s == ST_BYP) || (s == ST_BYP_PROG) || (s == ST_BYP_EXIT);
  endfunction
endpackage

// File: rtl/fcd_bus_strobe.sv
module fcd_bus_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic wr
);
  logic wr_lvl;
  logic wr_q;

  assign wr_lvl = !ce_n && !we_n && oe_n;
  assign wr     = wr_lvl && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b0;
    else        wr_q <= wr_lvl;
  end

  // one strobe per low phase of the write condition
  p_strobe_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> !wr);
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              accel,
  input  logic              busy,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              id_mode
);
  seq_state_t state, nxt;
  logic       accel_q;
  logic [7:0] cmd;
  logic       at_a1, at_a2, fire;

  assign cmd   = din[7:0];
  assign at_a1 = (addr[10:0] == UL_ADDR1);
  assign at_a2 = (addr[10:0] == UL_ADDR2);
  assign fire  = wr && !busy && ((state == ST_PROG) || (state == ST_BYP_PROG));

  always_comb begin
    nxt = state;
    if (wr) begin
      unique case (state)
        ST_READ:     if (at_a1 && cmd == CMD_UL1) nxt = ST_UL1;
        ST_UL1:      nxt = (at_a2 && cmd == CMD_UL2) ? ST_UL2 : ST_READ;
        ST_UL2: begin
          if (at_a1 && cmd == CMD_PROG)        nxt = ST_PROG;
          else if (at_a1 && cmd == CMD_AUTO)   nxt = ST_AUTO;
          else if (at_a1 && cmd == CMD_BYPASS) nxt = ST_BYP;
          else                                 nxt = ST_READ;
        end
        ST_PROG:     nxt = ST_READ;
        ST_AUTO:     if (cmd == CMD_RESET) nxt = ST_READ;
        ST_BYP: begin
          if (cmd == CMD_PROG)      nxt = ST_BYP_PROG;
          else if (cmd == CMD_AUTO) nxt = ST_BYP_EXIT;
        end
        ST_BYP_PROG: nxt = ST_BYP;
        ST_BYP_EXIT: nxt = (cmd == CMD_EXIT2) ? ST_READ : ST_BYP;
        default:     nxt = ST_READ;
      endcase
    end
    if (accel && !in_bypass(nxt))                      nxt = ST_BYP;
    else if (!accel && accel_q && in_bypass(nxt))      nxt = ST_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_READ;
      accel_q  <= 1'b0;
      prog_req <= 1'b0;
    end else begin
      state    <= nxt;
      accel_q  <= accel;
      prog_req <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_addr <= '0;
      prog_data <= '0;
    end else if (fire) begin
      prog_addr <= addr;
      prog_data <= din;
    end
  end

  assign id_mode = (state == ST_AUTO);

  p_req_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req);
  p_req_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> !$past(busy));
  p_accel_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accel && $past(accel) && $past(rst_n)) |-> in_bypass(state));
endmodule

// File: rtl/fcd_id_mux.sv
module fcd_id_mux #(
  parameter int          DATA_W = 16,
  parameter logic [7:0]  MFR_ID = 8'h01,
  parameter logic [7:0]  DEV_ID = 8'h7E
) (
  input  logic              id_mode,
  input  logic [1:0]        word_sel,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [DATA_W-1:0] dout
);
  logic [7:0] id_byte;

  always_comb begin
    unique case (word_sel)
      2'd0:    id_byte = MFR_ID;
      2'd1:    id_byte = DEV_ID;
      default: id_byte = 8'h00;
    endcase
  end

  assign dout = id_mode ? {{(DATA_W-8){1'b0}}, id_byte} : array_rdata;
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int         ADDR_W = 12,
  parameter int         DATA_W = 16,
  parameter logic [7:0] MFR_ID = 8'h01,
  parameter logic [7:0] DEV_ID = 8'h7E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              accel,
  input  logic              busy,
  input  logic [DATA_W-1:0] array_rdata,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              read_sel_id,
  output logic [DATA_W-1:0] dout
);
  logic [1:0] rst_sync;
  logic       rst_n_s;
  logic       wr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  fcd_bus_strobe u_strobe (
    .clk(clk), .rst_n(rst_n_s), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .wr(wr)
  );

  fcd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .wr(wr), .addr(addr), .din(din),
    .accel(accel), .busy(busy), .prog_req(prog_req), .prog_addr(prog_addr),
    .prog_data(prog_data), .id_mode(read_sel_id)
  );

  fcd_id_mux #(.DATA_W(DATA_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_id (
    .id_mode(read_sel_id), .word_sel(addr[1:0]),
    .array_rdata(array_rdata), .dout(dout)
  );

  p_id_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    read_sel_id |-> (dout[DATA_W-1:8] == '0));
  p_req_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    prog_req |-> $past(!ce_n && !we_n && oe_n));
endmodule

// File: tb/test_flash_cmd_decoder.sv
`timescale 1ns/1ps
module test_flash_cmd_decoder;
  localparam int AW = 12;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n, ce_n, we_n, oe_n, accel, busy;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, array_rdata;
  logic prog_req, read_sel_id;
  logic [AW-1:0] prog_addr;
  logic [DW-1:0] prog_data, dout;

  int n_cmp = 0, n_bad = 0;
  logic got_req;
  logic [AW-1:0] got_a;
  logic [DW-1:0] got_d;

  always #2.5 clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .accel(accel), .busy(busy),
    .array_rdata(array_rdata), .prog_req(prog_req), .prog_addr(prog_addr),
    .prog_data(prog_data), .read_sel_id(read_sel_id), .dout(dout)
  );

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic cen = 1'b0, input logic oen = 1'b1);
    @(negedge clk);
    ce_n = cen; we_n = 1'b0; oe_n = oen; addr = a; din = d;
    @(negedge clk);
    got_req = prog_req; got_a = prog_addr; got_d = prog_data;
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic unlock();
    bus_write(12'h555, 16'h00AA);
    chk(!got_req, "R2 no req step1", got_req, 0);
    bus_write(12'h2AA, 16'h0055);
    chk(!got_req, "R2 no req step2", got_req, 0);
  endtask

  task automatic read_at(input logic [AW-1:0] a);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    #1;
  endtask

  initial begin
    #100000;
    n_bad++; n_cmp++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; accel = 1'b0; busy = 1'b0;
    addr = '0; din = '0; array_rdata = 16'hC3A5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk(prog_req == 1'b0, "R11 prog_req", prog_req, 0);
    chk(read_sel_id == 1'b0, "R11 read_sel_id", read_sel_id, 0);
    read_at(12'h000);
    chk(dout == array_rdata, "R11 dout passthrough", dout, array_rdata);
    ce_n = 1'b1; oe_n = 1'b1;

    // R2 normal program sweep
    for (int i = 0; i < 8; i++) begin
      logic [AW-1:0] a; logic [DW-1:0] d;
      a = AW'(i * 12'h1F3 + 3); d = DW'(i * 16'h1357 + 16'h0101);
      unlock();
      bus_write(12'h555, 16'h00A0);
      chk(!got_req, "R2 no req step3", got_req, 0);
      bus_write(a, d);
      chk(got_req, "R2 req after 4th", got_req, 1);
      chk(got_a == a, "R2 prog_addr", got_a, a);
      chk(got_d == d, "R2 prog_data", got_d, d);
      // R10 one clock only
      chk(!prog_req, "R10 req width", prog_req, 0);
    end

    // R3 mismatch at each step, by data and by address
    for (int s = 0; s < 3; s++) begin
      for (int k = 0; k < 2; k++) begin
        logic [AW-1:0] a0, a1, a2; logic [DW-1:0] d0, d1, d2;
        a0 = 12'h555; a1 = 12'h2AA; a2 = 12'h555;
        d0 = 16'h00AA; d1 = 16'h0055; d2 = 16'h00A0;
        if (s == 0) begin if (k == 0) d0 = 16'h00AB; else a0 = 12'h554; end
        if (s == 1) begin if (k == 0) d1 = 16'h0056; else a1 = 12'h2AB; end
        if (s == 2) begin if (k == 0) d2 = 16'h0033; else a2 = 12'h556; end
        bus_write(a0, d0); bus_write(a1, d1); bus_write(a2, d2);
        bus_write(12'h123, 16'h4567);
        chk(!got_req, "R3 mismatch no req", got_req, 0);
        chk(!read_sel_id, "R3 back to read", read_sel_id, 0);
      end
    end

    // R1 non-write cycles are ignored
    unlock();
    bus_write(12'h555, 16'h00A0);
    bus_write(12'h0AB, 16'hBEEF, 1'b0, 1'b0);
    chk(!got_req, "R1 oe_n low ignored", got_req, 0);
    bus_write(12'h0AB, 16'hBEEF, 1'b1, 1'b1);
    chk(!got_req, "R1 ce_n high ignored", got_req, 0);
    bus_write(12'h0AC, 16'hCAFE);
    chk(got_req && got_d == 16'hCAFE, "R1 real write programs", got_d, 16'hCAFE);

    // R9 busy blocks request, sequence still ends
    busy = 1'b1;
    unlock(); bus_write(12'h555, 16'h00A0); bus_write(12'h010, 16'h1111);
    chk(!got_req, "R9 busy no req", got_req, 0);
    busy = 1'b0;
    bus_write(12'h010, 16'h2222);
    chk(!got_req, "R9 sequence ended", got_req, 0);

    // R4 bypass mode programs in two writes
    unlock(); bus_write(12'h555, 16'h0020);
    chk(!got_req, "R4 entry no req", got_req, 0);
    for (int i = 0; i < 6; i++) begin
      logic [AW-1:0] a; logic [DW-1:0] d;
      a = AW'(i * 12'h2B1 + 7); d = DW'(16'hF00F ^ (i * 16'h0F21));
      bus_write(12'h000, 16'h00A0);
      chk(!got_req, "R4 no req on A0", got_req, 0);
      bus_write(a, d);
      chk(got_req && got_a == a && got_d == d, "R4 bypass program", got_d, d);
    end

    // R5 exit: 90 then non-00 stays, 90 then 00 leaves
    bus_write(12'h000, 16'h0090); bus_write(12'h000, 16'h0011);
    bus_write(12'h000, 16'h00A0); bus_write(12'h044, 16'h5A5A);
    chk(got_req && got_d == 16'h5A5A, "R5 stays in bypass", got_d, 16'h5A5A);
    bus_write(12'h000, 16'h0090); bus_write(12'h000, 16'h0000);
    bus_write(12'h000, 16'h00A0); bus_write(12'h045, 16'h6B6B);
    chk(!got_req, "R5 normal after exit", got_req, 0);

    // R6 autoselect reads
    unlock(); bus_write(12'h555, 16'h0090);
    chk(read_sel_id, "R6 id mode", read_sel_id, 1);
    for (int w = 0; w < 4; w++) begin
      logic [DW-1:0] e;
      e = (w == 0) ? 16'h0001 : (w == 1) ? 16'h007E : 16'h0000;
      read_at(AW'(12'h340 + w));
      chk(dout == e, "R6 id word", dout, e);
    end
    ce_n = 1'b1; oe_n = 1'b1;
    bus_write(12'h000, 16'h0012);
    chk(read_sel_id, "R7 other write keeps autoselect", read_sel_id, 1);
    // R7 reset command
    bus_write(12'h000, 16'h00F0);
    chk(!read_sel_id, "R7 reset leaves id", read_sel_id, 0);
    read_at(12'h000);
    chk(dout == array_rdata, "R7 array data back", dout, array_rdata);
    ce_n = 1'b1; oe_n = 1'b1;

    // R8 accel forces bypass, release returns to normal
    @(negedge clk); accel = 1'b1;
    repeat (2) @(negedge clk);
    bus_write(12'h000, 16'h00A0); bus_write(12'h077, 16'h3C3C);
    chk(got_req && got_a == 12'h077, "R8 accel bypass program", got_a, 12'h077);
    bus_write(12'h000, 16'h0090); bus_write(12'h000, 16'h0000);
    bus_write(12'h000, 16'h00A0); bus_write(12'h078, 16'h3D3D);
    chk(got_req, "R8 exit ignored while accel", got_req, 1);
    @(negedge clk); accel = 1'b0;
    repeat (2) @(negedge clk);
    bus_write(12'h000, 16'h00A0); bus_write(12'h079, 16'h3E3E);
    chk(!got_req, "R8 normal after release", got_req, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule